// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital control core of a stand-alone single-wire LIN bus transceiver. It runs on one fixed clock and takes flags that have already been digitised: two supply reset comparators, two battery monitor comparators, an over-temperature flag, the received bus level and the EN and TxD pins. From these it keeps the power mode and drives the controls for the analog front end: transmitter enable, dominant drive, the open-drain receive output, the bus pull-up, the sleep bias source and the strength of the TxD pull-down.

The mode machine has four states: Unpowered (code 0), Sleep (code 1), Standby (code 2) and Normal (code 3). It has these transitions. Power-loss goes from any state to Unpowered. Power-up goes from Unpowered to Sleep. Remote-wake goes from Sleep to Standby. Enable goes from Sleep or Standby to Normal. Disable goes from Normal to Sleep. If Enable and Remote-wake qualify in the same cycle in Sleep, Enable wins. EN is filtered separately for the high and low directions. A remote wake needs a long dominant pulse that ends in a recessive edge. Transmission is gated by an over-temperature latch and by a battery monitor with hysteresis. Neither gate changes the mode. There is no dominant timeout on TxD, so low bit rates have no lower limit. All filter times are parameters counted in clock cycles.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rst_n is low, mode_o is 0 (Unpowered) and tx_en_o, drive_dom_o, rxd_low_o, pullup_en_o, bias_en_o and txd_pd_strong_o are all 0.
- R2: sup_rst_low high moves every mode to Unpowered at the next clock edge. Unpowered moves to Sleep (code 1) at the next edge once sup_rst_ok is high and sup_rst_low is low. Without sup_rst_ok the block stays in Unpowered.
- R3: In Sleep or Standby, EN held high for more than EN_CYC consecutive clock cycles moves the mode to Normal (code 3). A high pulse of EN_CYC cycles or fewer leaves the mode unchanged.
- R4: In Normal, EN held low for more than DIS_CYC consecutive clock cycles moves the mode to Sleep. A low pulse of DIS_CYC cycles or fewer leaves the mode in Normal.
- R5: In Sleep, bus_rx low (0 = dominant) for at least WAKE_CYC consecutive cycles and then a return to high moves the mode to Standby (code 2) within three cycles of that edge. A shorter dominant pulse, or a dominant level that has not yet ended, leaves the mode in Sleep.
- R6: In Standby, pullup_en_o is 1, and rxd_low_o and txd_pd_strong_o are 1 while EN is low. Two cycles after EN rises, both are 0, while the mode is still Standby.
- R7: In Unpowered and Sleep, rxd_low_o, tx_en_o and pullup_en_o are 0. bias_en_o is 1 in Sleep only.
- R8: In Normal, pullup_en_o is 1 and rxd_low_o equals the inverse of bus_rx two cycles later. drive_dom_o is 1 two cycles after TxD goes low while tx_en_o is 1. It stays 1 however long TxD stays low.
- R9: tsd_hot high forces tx_en_o and drive_dom_o to 0 at the next edge. After tsd_hot clears, tx_en_o stays 0 until TxD has been seen high, and returns three cycles after TxD rises.
- R10: bat_low high forces tx_en_o to 0 at the next edge. tx_en_o returns only when bat_ok is high. Throughout, the mode stays Normal and rxd_low_o keeps following the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_rst_low | input | 1 | Supply is below the low reset threshold |
| sup_rst_ok | input | 1 | Supply is above the high reset threshold |
| bat_low | input | 1 | Battery is below the monitor low threshold |
| bat_ok | input | 1 | Battery is at or above the monitor high threshold |
| tsd_hot | input | 1 | Junction over-temperature flag |
| bus_rx | input | 1 | Received bus level, 0 = dominant |
| en_pin | input | 1 | EN pin level |
| txd_pin | input | 1 | TxD pin level, 0 = dominant request |
| mode_o | output | 2 | Mode: 0 Unpowered, 1 Sleep, 2 Standby, 3 Normal |
| tx_en_o | output | 1 | Transmitter allowed |
| drive_dom_o | output | 1 | Drive the bus dominant |
| rxd_low_o | output | 1 | 1 = pull RxD low, 0 = high-impedance |
| pullup_en_o | output | 1 | Bus pull-up enabled |
| bias_en_o | output | 1 | Small sleep bias source on the bus |
| txd_pd_strong_o | output | 1 | 1 = strong TxD pull-down, 0 = weak |

## Verification
The bench builds the block with EN_CYC = 4, DIS_CYC = 5 and WAKE_CYC = 6. With these short filters, every pulse length from one cycle to a few cycles past each threshold can be swept, so the cycle where each filter starts to act is hit exactly on both sides. The same small values keep the wake, enable and disable round trips short. The bench can then enter Standby for every qualifying dominant length and return through Normal to Sleep, and can hold TxD low for many times any filter length.

// File: rtl/lin_mc_pkg.sv
package lin_mc_pkg;

    typedef enum logic [1:0] {
        M_UNPOW = 2'd0,
        M_SLEEP = 2'd1,
        M_STBY  = 2'd2,
        M_NORM  = 2'd3
    } mode_e;

    typedef struct packed {
        logic tx_en;
        logic drive_dom;
        logic rxd_low;
        logic pullup_en;
        logic bias_en;
        logic pd_strong;
    } pin_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lin_mc_sync.sv
module lin_mc_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/lin_mc_filt.sv
module lin_mc_filt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic full,
    output logic hit
);

    localparam int CW = lin_mc_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!level) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == TOP);
    assign hit  = level && full;

endmodule

// File: rtl/lin_mc_txgate.sv
module lin_mc_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic in_normal,
    input  logic tsd_hot,
    input  logic bat_low,
    input  logic bat_ok,
    input  logic txd_s,
    output logic tx_en,
    output logic drive_dom,
    output logic tsd_blk,
    output logic bat_blk
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsd_blk <= 1'b0;
        end else if (tsd_hot) begin
            tsd_blk <= 1'b1;
        end else if (txd_s) begin
            tsd_blk <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bat_blk <= 1'b0;
        end else if (bat_low) begin
            bat_blk <= 1'b1;
        end else if (bat_ok) begin
            bat_blk <= 1'b0;
        end
    end

    always_comb begin
        tx_en     = in_normal && !tsd_blk && !bat_blk;
        drive_dom = tx_en && !txd_s;
    end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EN_CYC      = 400,
    parameter int DIS_CYC     = 400,
    parameter int WAKE_CYC    = 1400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_rst_low,
    input  logic       sup_rst_ok,
    input  logic       bat_low,
    input  logic       bat_ok,
    input  logic       tsd_hot,
    input  logic       bus_rx,
    input  logic       en_pin,
    input  logic       txd_pin,
    output logic [1:0] mode_o,
    output logic       tx_en_o,
    output logic       drive_dom_o,
    output logic       rxd_low_o,
    output logic       pullup_en_o,
    output logic       bias_en_o,
    output logic       txd_pd_strong_o
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_vec;
    logic [NSYNC-1:0] syn_vec;
    logic             en_s;
    logic             txd_s;
    logic             bus_s;
    logic             bus_q;
    logic             bus_rise;

    logic en_full, en_hit;
    logic dis_full, dis_hit;
    logic dom_full, dom_hit;
    logic wake_hit;

    logic tx_en, drive_dom, tsd_blk, bat_blk;

    mode_e    cur, nxt;
    pin_ctl_t ctl;

    assign raw_vec = {bus_rx, txd_pin, en_pin};

    lin_mc_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (NSYNC),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (syn_vec)
    );

    assign en_s  = syn_vec[0];
    assign txd_s = syn_vec[1];
    assign bus_s = syn_vec[2];

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= 1'b1;
        else        bus_q <= bus_s;
    end

    assign bus_rise = bus_s && !bus_q;

    lin_mc_filt #(.LIMIT(EN_CYC)) u_en_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .level (en_s),
        .full  (en_full),
        .hit   (en_hit)
    );

    lin_mc_filt #(.LIMIT(DIS_CYC)) u_dis_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .level (!en_s),
        .full  (dis_full),
        .hit   (dis_hit)
    );

    lin_mc_filt #(.LIMIT(WAKE_CYC)) u_wake_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .level (!bus_s),
        .full  (dom_full),
        .hit   (dom_hit)
    );

    assign wake_hit = bus_rise && dom_full;

    lin_mc_txgate u_txgate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_normal (cur == M_NORM),
        .tsd_hot   (tsd_hot),
        .bat_low   (bat_low),
        .bat_ok    (bat_ok),
        .txd_s     (txd_s),
        .tx_en     (tx_en),
        .drive_dom (drive_dom),
        .tsd_blk   (tsd_blk),
        .bat_blk   (bat_blk)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= M_UNPOW;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (sup_rst_low) begin
            nxt = M_UNPOW;
        end else begin
            unique case (cur)
                M_UNPOW: if (sup_rst_ok) nxt = M_SLEEP;
                M_SLEEP: begin
                    if (en_hit)        nxt = M_NORM;
                    else if (wake_hit) nxt = M_STBY;
                end
                M_STBY:  if (en_hit)  nxt = M_NORM;
                M_NORM:  if (dis_hit) nxt = M_SLEEP;
                default: nxt = M_UNPOW;
            endcase
        end
    end

    always_comb begin
        ctl = '0;
        unique case (cur)
            M_UNPOW: ctl = '0;
            M_SLEEP: ctl.bias_en = 1'b1;
            M_STBY: begin
                ctl.pullup_en = 1'b1;
                ctl.rxd_low   = !en_s;
                ctl.pd_strong = !en_s;
            end
            M_NORM: begin
                ctl.pullup_en = 1'b1;
                ctl.rxd_low   = !bus_s;
            end
            default: ctl = '0;
        endcase
        ctl.tx_en     = tx_en;
        ctl.drive_dom = drive_dom;
    end

    assign mode_o          = cur;
    assign tx_en_o         = ctl.tx_en;
    assign drive_dom_o     = ctl.drive_dom;
    assign rxd_low_o       = ctl.rxd_low;
    assign pullup_en_o     = ctl.pullup_en;
    assign bias_en_o       = ctl.bias_en;
    assign txd_pd_strong_o = ctl.pd_strong;

endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_rst_low,
    input logic       tsd_hot,
    input logic [1:0] mode_o,
    input logic       tx_en_o,
    input logic       drive_dom_o,
    input logic       rxd_low_o,
    input logic       pullup_en_o,
    input logic       en_s,
    input logic       txd_s,
    input logic       tsd_blk
);

    p_power_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sup_rst_low |=> (mode_o == 2'd0));

    p_unpow_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |=> (mode_o == 2'd0 || mode_o == 2'd1));

    p_normal_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd3) |=> (mode_o != 2'd3 || $past(en_s)));

    p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 || mode_o == 2'd1) |-> (!rxd_low_o && !tx_en_o && !pullup_en_o));

    p_drive_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_dom_o |-> (tx_en_o && mode_o == 2'd3));

    p_hot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_hot |=> !tx_en_o);

    p_rearm_txd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tsd_blk) |-> ($past(txd_s) && !$past(tsd_hot)));

endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_rst_low (sup_rst_low),
    .tsd_hot     (tsd_hot),
    .mode_o      (mode_o),
    .tx_en_o     (tx_en_o),
    .drive_dom_o (drive_dom_o),
    .rxd_low_o   (rxd_low_o),
    .pullup_en_o (pullup_en_o),
    .en_s        (en_s),
    .txd_s       (txd_s),
    .tsd_blk     (tsd_blk)
);

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb;

    localparam int EN_CYC   = 4;
    localparam int DIS_CYC  = 5;
    localparam int WAKE_CYC = 6;

    logic clk = 1'b0;
    logic rst_n, sup_rst_low, sup_rst_ok, bat_low, bat_ok, tsd_hot;
    logic bus_rx, en_pin, txd_pin;
    logic [1:0] mode_o;
    logic tx_en_o, drive_dom_o, rxd_low_o, pullup_en_o, bias_en_o, txd_pd_strong_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lin_mode_ctrl #(
        .SYNC_STAGES (2),
        .EN_CYC      (EN_CYC),
        .DIS_CYC     (DIS_CYC),
        .WAKE_CYC    (WAKE_CYC)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sup_rst_low     (sup_rst_low),
        .sup_rst_ok      (sup_rst_ok),
        .bat_low         (bat_low),
        .bat_ok          (bat_ok),
        .tsd_hot         (tsd_hot),
        .bus_rx          (bus_rx),
        .en_pin          (en_pin),
        .txd_pin         (txd_pin),
        .mode_o          (mode_o),
        .tx_en_o         (tx_en_o),
        .drive_dom_o     (drive_dom_o),
        .rxd_low_o       (rxd_low_o),
        .pullup_en_o     (pullup_en_o),
        .bias_en_o       (bias_en_o),
        .txd_pd_strong_o (txd_pd_strong_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic leave_standby();
        en_pin = 1'b1;
        step(EN_CYC + 6);
        chk("R3 standby to normal", mode_o, 3);
        en_pin = 1'b0;
        step(DIS_CYC + 6);
        chk("R4 back to sleep", mode_o, 1);
    endtask

    initial begin
        rst_n = 1'b0; sup_rst_low = 1'b0; sup_rst_ok = 1'b1;
        bat_low = 1'b0; bat_ok = 1'b1; tsd_hot = 1'b0;
        bus_rx = 1'b1; en_pin = 1'b0; txd_pin = 1'b1;
        step(3);
        chk("R1 mode", mode_o, 0);
        chk("R1 outputs", {tx_en_o, drive_dom_o, rxd_low_o, pullup_en_o, bias_en_o, txd_pd_strong_o}, 0);
        rst_n = 1'b1;
        step(1);
        chk("R2 power-up", mode_o, 1);
        chk("R7 sleep bias", bias_en_o, 1);
        chk("R7 sleep quiet", {rxd_low_o, tx_en_o, pullup_en_o}, 0);

        // R3: enable filter sweep from Sleep
        for (int len = 1; len <= EN_CYC + 3; len++) begin
            en_pin = 1'b1;
            step(len);
            en_pin = 1'b0;
            step(2);
            chk("R3 enable pulse", mode_o, (len > EN_CYC) ? 3 : 1);
            step(DIS_CYC + 8);
            chk("R4 settle sleep", mode_o, 1);
        end

        en_pin = 1'b1;
        step(EN_CYC + 4);
        chk("R3 normal", mode_o, 3);
        chk("R8 pullup", pullup_en_o, 1);
        chk("R8 tx enabled", tx_en_o, 1);
        chk("R8 recessive drive", drive_dom_o, 0);

        // R8: reception and transmission in Normal
        bus_rx = 1'b0; step(2);
        chk("R8 rx dominant", rxd_low_o, 1);
        bus_rx = 1'b1; step(2);
        chk("R8 rx recessive", rxd_low_o, 0);
        txd_pin = 1'b0; step(2);
        chk("R8 drive dominant", drive_dom_o, 1);
        step(200);
        chk("R8 no timeout", drive_dom_o, 1);

        // R9: thermal latch
        tsd_hot = 1'b1; step(1);
        chk("R9 hot tx off", tx_en_o, 0);
        chk("R9 hot released", drive_dom_o, 0);
        tsd_hot = 1'b0; step(4);
        chk("R9 wait txd high", tx_en_o, 0);
        txd_pin = 1'b1; step(3);
        chk("R9 rearmed", tx_en_o, 1);
        txd_pin = 1'b0; step(2);
        chk("R9 drive again", drive_dom_o, 1);
        txd_pin = 1'b1; step(2);

        // R10: battery hysteresis
        bat_low = 1'b1; bat_ok = 1'b0; step(1);
        chk("R10 bat low tx off", tx_en_o, 0);
        chk("R10 mode kept", mode_o, 3);
        bat_low = 1'b0; step(3);
        chk("R10 still blocked", tx_en_o, 0);
        bus_rx = 1'b0; step(2);
        chk("R10 reception kept", rxd_low_o, 1);
        bus_rx = 1'b1; step(2);
        bat_ok = 1'b1; step(1);
        chk("R10 re-enabled", tx_en_o, 1);

        // R4: disable filter sweep from Normal
        for (int len = 1; len <= DIS_CYC + 3; len++) begin
            en_pin = 1'b0;
            step(len);
            en_pin = 1'b1;
            step(2);
            chk("R4 disable pulse", mode_o, (len > DIS_CYC) ? 1 : 3);
            step(EN_CYC + 8);
            chk("R3 settle normal", mode_o, 3);
        end

        en_pin = 1'b0;
        step(DIS_CYC + 6);
        chk("R4 sleep", mode_o, 1);

        // R5/R6: wake sweep
        for (int len = 1; len <= WAKE_CYC + 2; len++) begin
            bus_rx = 1'b0;
            step(len);
            bus_rx = 1'b1;
            step(3);
            chk("R5 wake pulse", mode_o, (len >= WAKE_CYC) ? 2 : 1);
            if (len >= WAKE_CYC) begin
                chk("R6 rxd flag", rxd_low_o, 1);
                chk("R6 strong pd", txd_pd_strong_o, 1);
                chk("R6 pullup", pullup_en_o, 1);
                en_pin = 1'b1;
                step(2);
                chk("R6 early release", {rxd_low_o, txd_pd_strong_o}, 0);
                chk("R6 still standby", mode_o, 2);
                leave_standby();
            end
        end

        bus_rx = 1'b0;
        step(3 * WAKE_CYC);
        chk("R5 no edge yet", mode_o, 1);
        bus_rx = 1'b1;
        step(3);
        chk("R5 edge wakes", mode_o, 2);
        leave_standby();

        // R2: power loss from Normal
        en_pin = 1'b1;
        step(EN_CYC + 4);
        chk("R3 normal again", mode_o, 3);
        sup_rst_low = 1'b1; sup_rst_ok = 1'b0; step(1);
        chk("R2 power loss", mode_o, 0);
        chk("R2 safe outputs", {tx_en_o, rxd_low_o, pullup_en_o, bias_en_o}, 0);
        sup_rst_low = 1'b0; step(3);
        chk("R2 wait ok", mode_o, 0);
        sup_rst_ok = 1'b1; step(1);
        chk("R2 power-up again", mode_o, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule